// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block sits on the host side of a configuration fabric. It offers the CPU two ports on a small register bus. The first is a 32-bit address port that holds a latched target address. The second is a data window, which turns each host read or write into one configuration-space access. That access goes to a downstream function, selected by bus number and device/function number.

Bit 31 of the latched address gates the data window. The two low bits of the window offset are merged into the target byte offset. Any access that would run past the end of the configuration space is shortened. When the window is closed, or no function answers, a read returns all ones and a write is dropped. A build-time parameter selects little-endian or big-endian byte order for host data on both ports.

Each host access is one valid/ready handshake. The host holds its request fields stable until `h_ready` pulses for one cycle. While a downstream request is outstanding, the bridge holds `h_ready` low.

Top module: `cfg_port_bridge`

## Requirements
- R1: The address register loads only from an address-port write (`h_sel`=0) with `h_offset`=0 and `h_len`=4. An address-port write with any other offset or length leaves the register unchanged.
- R2: An address-port read returns the whole 32-bit latched register for any `h_offset` and `h_len`.
- R3: After reset, the latched register is zero. `h_ready` and `d_req` are low, so the data window starts disabled.
- R4: While register bit 31 is 0, a data-port read completes in one cycle with 0xFFFFFFFF. A data-port write completes in one cycle. Neither raises `d_req`.
- R5: The target address is the register OR'd with `h_offset`. Target bits 23:16 drive `d_bus` and bits 15:8 drive `d_devfn`. Bits 7:0, reduced to the configuration space (256 bytes by default), drive `d_reg`. Register bits 30:24 have no effect.
- R6: `d_len` equals the smaller of `h_len` and (space size minus `d_reg`). For example, `d_reg`=0xFF with `h_len`=4 gives `d_len`=1.
- R7: `d_be` has `d_len` consecutive bits set, starting at bit `d_reg[1:0]`. Bits above lane 3 are dropped. The write data is shifted up by 8×`d_reg[1:0]` bits onto the matching lanes of `d_wdata`.
- R8: Read data is taken from the downstream lanes starting at lane `d_reg[1:0]` and returned from byte 0 of `h_rdata`. Bytes at or beyond `d_len` read as zero. A write returns 0 on `h_rdata`.
- R9: When `d_absent` answers a request, a read returns 0xFFFFFFFF and a write changes no device state.
- R10: `h_ready` is a single-cycle pulse. An enabled data access holds `d_req`, with stable fields, until `d_ack` or `d_absent` arrives. `h_ready` follows one cycle later.
- R11: With `BIG_ENDIAN`=1, host data is byte-reversed within the `h_len` bytes of the access, in both directions and on both ports (always 4 bytes for the address port).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_valid | input | 1 | Host access request |
| h_ready | output | 1 | One-cycle completion pulse |
| h_write | input | 1 | 1 = write, 0 = read |
| h_sel | input | 1 | 0 = address port, 1 = data window |
| h_offset | input | 2 | Byte offset within the port |
| h_len | input | 3 | Access length in bytes (1 to 4) |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid with h_ready |
| d_req | output | 1 | Downstream configuration request |
| d_write | output | 1 | Downstream request is a write |
| d_bus | output | 8 | Target bus number |
| d_devfn | output | 8 | Target device/function |
| d_reg | output | $clog2(CFG_BYTES) | Register byte offset |
| d_len | output | 3 | Clipped byte count |
| d_be | output | 4 | Lane byte enables |
| d_wdata | output | 32 | Lane-aligned write data |
| d_rdata | input | 32 | Lane-aligned read data |
| d_ack | input | 1 | Target present, access done |
| d_absent | input | 1 | No function at bus/devfn |

## Verification
End-of-space clipping and offset merging take effect in the same cycle. The window offset's low bits are OR'd into the register offset, and the result decides both the start lane and how many bytes remain. The bench provokes this with register offsets 0xFC and 0xFE plus non-zero window offsets and 4-byte lengths. It judges the captured `d_reg`, `d_len` and `d_be`, and the right-aligned, zero-padded read data, against its own model. A second instance built for big-endian order shows byte reversal and lane placement acting together on the same access.

// File: rtl/cfg_bridge_pkg.sv
package cfg_bridge_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_e;

  // shortest of the requested count, a 4-byte cap and the room left
  function automatic logic [2:0] clip_len(input logic [2:0] req, input int room);
    int n;
    n = (req > 3'd4) ? 4 : int'(req);
    if (room < n) n = room;
    return 3'(n);
  endfunction

  // n consecutive lanes starting at lane lo, lanes above 3 dropped
  function automatic logic [3:0] lane_mask(input logic [2:0] n, input logic [1:0] lo);
    logic [7:0] m;
    m = ((8'd1 << n) - 8'd1) << lo;
    return m[3:0];
  endfunction

  // zero every byte at or above position n
  function automatic logic [31:0] keep_bytes(input logic [31:0] d, input logic [2:0] n);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 4; i++) begin
      if (i < int'(n)) r[8*i +: 8] = d[8*i +: 8];
    end
    return r;
  endfunction

  // reverse the low n bytes when big is set
  function automatic logic [31:0] order_bytes(input logic [31:0] d, input logic [2:0] n,
                                              input logic big);
    logic [31:0] r;
    int k;
    if (!big) return d;
    r = '0;
    for (int i = 0; i < 4; i++) begin
      k = (int'(n) - 1 - i) & 3;
      if (i < int'(n)) r[8*i +: 8] = d[8*k +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch #(
  parameter int EN_BIT = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  logic        h_write,
  input  logic        h_sel,
  input  logic [1:0]  h_offset,
  input  logic [2:0]  h_len,
  input  logic [31:0] wdata,
  output logic [31:0] addr_reg,
  output logic        port_en,
  output logic        latch_fire
);

  assign latch_fire = accept && h_write && !h_sel && (h_offset == 2'd0) && (h_len == 3'd4);
  assign port_en    = addr_reg[EN_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) addr_reg <= '0;
    else if (latch_fire) addr_reg <= wdata;
  end

endmodule

// File: rtl/cfg_target_decode.sv
module cfg_target_decode
  import cfg_bridge_pkg::*;
#(
  parameter int CFG_BYTES = 256,
  parameter int OFS_W     = $clog2(CFG_BYTES)
) (
  input  logic [31:0]      addr_reg,
  input  logic [1:0]       h_offset,
  input  logic [2:0]       h_len,
  input  logic [31:0]      wdata,
  input  logic [31:0]      d_rdata,
  output logic [7:0]       bus,
  output logic [7:0]       devfn,
  output logic [OFS_W-1:0] reg_ofs,
  output logic [2:0]       len_clip,
  output logic [3:0]       be,
  output logic [31:0]      lane_wdata,
  output logic [31:0]      aligned_rdata
);

  logic [7:0] tgt_lo;
  logic [1:0] lo2;
  logic [4:0] sh;

  assign tgt_lo        = addr_reg[7:0] | {6'd0, h_offset};
  assign bus           = addr_reg[23:16];
  assign devfn         = addr_reg[15:8];
  assign reg_ofs       = tgt_lo[OFS_W-1:0];
  assign lo2           = reg_ofs[1:0];
  assign sh            = {lo2, 3'b000};
  assign len_clip      = clip_len(h_len, CFG_BYTES - int'(reg_ofs));
  assign be            = lane_mask(len_clip, lo2);
  assign lane_wdata    = wdata << sh;
  assign aligned_rdata = keep_bytes(d_rdata >> sh, len_clip);

endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_valid,
  input  logic        h_write,
  input  logic        h_sel,
  input  logic        port_en,
  input  logic        d_ack,
  input  logic        d_absent,
  input  logic [31:0] imm_data,
  input  logic [31:0] down_data,
  output logic        h_ready,
  output logic [31:0] h_rdata,
  output logic        d_req,
  output logic        accept
);

  seq_state_e  st;
  logic [31:0] rsp;

  assign accept  = (st == SEQ_IDLE) && h_valid;
  assign h_ready = (st == SEQ_DONE);
  assign d_req   = (st == SEQ_WAIT);
  assign h_rdata = rsp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= SEQ_IDLE;
      rsp <= '0;
    end else begin
      case (st)
        SEQ_IDLE: begin
          if (h_valid) begin
            if (h_sel && port_en) begin
              st <= SEQ_WAIT;
            end else begin
              st  <= SEQ_DONE;
              rsp <= h_write ? '0 : imm_data;
            end
          end
        end
        SEQ_WAIT: begin
          if (d_ack || d_absent) begin
            st  <= SEQ_DONE;
            rsp <= h_write ? '0 : (d_absent ? '1 : down_data);
          end
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfg_bridge_pkg::*;
#(
  parameter int CFG_BYTES  = 256,
  parameter bit BIG_ENDIAN = 1'b0,
  localparam int OFS_W     = $clog2(CFG_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_valid,
  output logic             h_ready,
  input  logic             h_write,
  input  logic             h_sel,
  input  logic [1:0]       h_offset,
  input  logic [2:0]       h_len,
  input  logic [31:0]      h_wdata,
  output logic [31:0]      h_rdata,
  output logic             d_req,
  output logic             d_write,
  output logic [7:0]       d_bus,
  output logic [7:0]       d_devfn,
  output logic [OFS_W-1:0] d_reg,
  output logic [2:0]       d_len,
  output logic [3:0]       d_be,
  output logic [31:0]      d_wdata,
  input  logic [31:0]      d_rdata,
  input  logic             d_ack,
  input  logic             d_absent
);

  logic [31:0] addr_reg;
  logic        port_en;
  logic        accept;
  logic        latch_fire;
  logic [31:0] host_wdata;
  logic [31:0] rd_aligned;
  logic [31:0] rd_host;
  logic [31:0] imm_data;

  assign host_wdata = order_bytes(h_wdata, h_len, BIG_ENDIAN);
  assign rd_host    = order_bytes(rd_aligned, h_len, BIG_ENDIAN);
  assign imm_data   = h_sel ? '1 : order_bytes(addr_reg, 3'd4, BIG_ENDIAN);
  assign d_write    = h_write;

  cfg_addr_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .h_write   (h_write),
    .h_sel     (h_sel),
    .h_offset  (h_offset),
    .h_len     (h_len),
    .wdata     (host_wdata),
    .addr_reg  (addr_reg),
    .port_en   (port_en),
    .latch_fire(latch_fire)
  );

  cfg_target_decode #(.CFG_BYTES(CFG_BYTES), .OFS_W(OFS_W)) u_dec (
    .addr_reg     (addr_reg),
    .h_offset     (h_offset),
    .h_len        (h_len),
    .wdata        (host_wdata),
    .d_rdata      (d_rdata),
    .bus          (d_bus),
    .devfn        (d_devfn),
    .reg_ofs      (d_reg),
    .len_clip     (d_len),
    .be           (d_be),
    .lane_wdata   (d_wdata),
    .aligned_rdata(rd_aligned)
  );

  cfg_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .h_valid  (h_valid),
    .h_write  (h_write),
    .h_sel    (h_sel),
    .port_en  (port_en),
    .d_ack    (d_ack),
    .d_absent (d_absent),
    .imm_data (imm_data),
    .down_data(rd_host),
    .h_ready  (h_ready),
    .h_rdata  (h_rdata),
    .d_req    (d_req),
    .accept   (accept)
  );

endmodule

// File: rtl/cfg_port_bridge_chk.sv
module cfg_port_bridge_chk #(
  parameter int CFG_BYTES = 256,
  parameter int OFS_W     = $clog2(CFG_BYTES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             h_valid,
  input logic             h_ready,
  input logic             h_write,
  input logic             h_sel,
  input logic [1:0]       h_offset,
  input logic [2:0]       h_len,
  input logic [31:0]      h_rdata,
  input logic             d_req,
  input logic             d_write,
  input logic [7:0]       d_bus,
  input logic [7:0]       d_devfn,
  input logic [OFS_W-1:0] d_reg,
  input logic [2:0]       d_len,
  input logic             d_ack,
  input logic             d_absent,
  input logic             port_en,
  input logic [31:0]      addr_reg
);

  // R10: completion is a single-cycle pulse
  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    h_ready |=> !h_ready);

  // R10: an unanswered request stays up with unchanged target fields
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && !d_ack && !d_absent) |=>
      (d_req && $stable(d_bus) && $stable(d_devfn) && $stable(d_reg)));

  // R4: no downstream traffic while the window is closed
  a_r4_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    d_req |-> port_en);

  // R6: forwarded length never runs past the end of the space
  a_r6_len_fits: assert property (@(posedge clk) disable iff (!rst_n)
    d_req |-> ((d_len <= 3'd4) && (int'(d_len) <= CFG_BYTES - int'(d_reg))));

  // R9: absent target answers a read with all ones
  a_r9_absent_ones: assert property (@(posedge clk) disable iff (!rst_n)
    $past(d_req && d_absent && !d_write) |-> (h_ready && (h_rdata == 32'hFFFF_FFFF)));

  // R1: the register moves only on a full-width offset-0 address write
  a_r1_reg_guard: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_valid && h_write && !h_sel && (h_offset == 2'd0) && (h_len == 3'd4))
      |=> $stable(addr_reg));

endmodule

bind cfg_port_bridge cfg_port_bridge_chk #(.CFG_BYTES(CFG_BYTES), .OFS_W(OFS_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .h_valid (h_valid),
  .h_ready (h_ready),
  .h_write (h_write),
  .h_sel   (h_sel),
  .h_offset(h_offset),
  .h_len   (h_len),
  .h_rdata (h_rdata),
  .d_req   (d_req),
  .d_write (d_write),
  .d_bus   (d_bus),
  .d_devfn (d_devfn),
  .d_reg   (d_reg),
  .d_len   (d_len),
  .d_ack   (d_ack),
  .d_absent(d_absent),
  .port_en (port_en),
  .addr_reg(addr_reg)
);

// File: tb/cfg_port_bridge_tb_top.sv
`timescale 1ns/1ps
module cfg_port_bridge_tb_top;

  localparam int LAT = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        h_valid = 1'b0, h_valid_b = 1'b0;
  logic        h_write = 1'b0, h_sel = 1'b0;
  logic [1:0]  h_offset = '0;
  logic [2:0]  h_len = 3'd4;
  logic [31:0] h_wdata = '0;
  logic        h_ready, h_ready_b;
  logic [31:0] h_rdata, h_rdata_b;

  logic        d_req, d_write;
  logic [7:0]  d_bus, d_devfn, d_reg;
  logic [2:0]  d_len;
  logic [3:0]  d_be;
  logic [31:0] d_wdata;
  logic [31:0] d_rdata = '0;
  logic        d_ack = 1'b0, d_absent = 1'b0;

  logic        d_req_b, d_write_b;
  logic [7:0]  d_bus_b, d_devfn_b, d_reg_b;
  logic [2:0]  d_len_b;
  logic [3:0]  d_be_b;
  logic [31:0] d_wdata_b;

  cfg_port_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_ready(h_ready), .h_write(h_write),
    .h_sel(h_sel), .h_offset(h_offset), .h_len(h_len), .h_wdata(h_wdata), .h_rdata(h_rdata),
    .d_req(d_req), .d_write(d_write), .d_bus(d_bus), .d_devfn(d_devfn), .d_reg(d_reg),
    .d_len(d_len), .d_be(d_be), .d_wdata(d_wdata), .d_rdata(d_rdata), .d_ack(d_ack),
    .d_absent(d_absent)
  );

  cfg_port_bridge #(.BIG_ENDIAN(1'b1)) dut_be_i (
    .clk(clk), .rst_n(rst_n), .h_valid(h_valid_b), .h_ready(h_ready_b), .h_write(h_write),
    .h_sel(h_sel), .h_offset(h_offset), .h_len(h_len), .h_wdata(h_wdata), .h_rdata(h_rdata_b),
    .d_req(d_req_b), .d_write(d_write_b), .d_bus(d_bus_b), .d_devfn(d_devfn_b), .d_reg(d_reg_b),
    .d_len(d_len_b), .d_be(d_be_b), .d_wdata(d_wdata_b), .d_rdata(32'h4433_2211),
    .d_ack(d_req_b), .d_absent(1'b0)
  );

  int checks = 0;
  int bad = 0;

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // device storage: bus 0, device/function 0..7 present
  logic [7:0] mem [0:7][0:255];

  // responder log
  logic        seen = 1'b0;
  logic [7:0]  s_bus, s_dev, s_reg;
  logic [2:0]  s_len;
  logic [3:0]  s_be;
  logic [31:0] s_wd;
  logic [31:0] cap_b_wd;
  logic [7:0]  cap_b_reg;
  int          cnt = 0;

  always @(negedge clk) begin
    if (d_req_b) begin
      cap_b_wd  = d_wdata_b;
      cap_b_reg = d_reg_b;
    end
    if (!d_req) begin
      cnt = 0;
      d_ack = 1'b0;
      d_absent = 1'b0;
    end else if (!d_ack && !d_absent) begin
      cnt++;
      if (cnt == LAT) begin
        seen = 1'b1;
        s_bus = d_bus; s_dev = d_devfn; s_reg = d_reg; s_len = d_len; s_be = d_be;
        s_wd = d_wdata;
        if (d_bus == 8'd0 && d_devfn < 8'd8) begin
          for (int ln = 0; ln < 4; ln++) begin
            d_rdata[8*ln +: 8] = mem[d_devfn[2:0]][{d_reg[7:2], 2'(ln)}];
            if (d_write && d_be[ln]) mem[d_devfn[2:0]][{d_reg[7:2], 2'(ln)}] = d_wdata[8*ln +: 8];
          end
          d_ack = 1'b1;
        end else begin
          d_absent = 1'b1;
        end
      end
    end
  end

  // ---------------- reference model ----------------
  logic [31:0] m_cfg = '0;

  function automatic int room_n(input int o, input int len);
    return (len < 256 - o) ? len : 256 - o;
  endfunction

  function automatic logic [31:0] exp_read(input logic [31:0] cfg, input logic [1:0] off,
                                           input int len);
    logic [31:0] t, r;
    int o, n, dev;
    if (!cfg[31]) return 32'hFFFF_FFFF;
    t = cfg | {30'd0, off};
    dev = int'(t[15:8]);
    if (t[23:16] != 8'd0 || dev >= 8) return 32'hFFFF_FFFF;
    o = int'(t[7:0]);
    n = room_n(o, len);
    r = '0;
    for (int i = 0; i < n; i++) begin
      if ((o % 4) + i < 4) r[8*i +: 8] = mem[dev][(o / 4) * 4 + (o % 4) + i];
    end
    return r;
  endfunction

  task automatic acc(input bit on_be, input bit sel, input bit wr, input logic [1:0] off,
                     input logic [2:0] len, input logic [31:0] wd, input int exp_lat,
                     input bit exp_req, input string req, output logic [31:0] rd);
    logic rdy, rq;
    rd = 'x;
    @(negedge clk);
    h_sel = sel; h_write = wr; h_offset = off; h_len = len; h_wdata = wd;
    seen = 1'b0;
    if (on_be) h_valid_b = 1'b1; else h_valid = 1'b1;
    for (int cyc = 1; cyc <= 40; cyc++) begin
      @(posedge clk); #1;
      rdy = on_be ? h_ready_b : h_ready;
      rq  = on_be ? d_req_b : d_req;
      chk("R10", "h_ready timing", {31'd0, rdy}, {31'd0, cyc == exp_lat});
      chk(req, "d_req level", {31'd0, rq}, {31'd0, exp_req && cyc < exp_lat});
      if (rdy) begin
        rd = on_be ? h_rdata_b : h_rdata;
        break;
      end
    end
    @(negedge clk);
    h_valid = 1'b0;
    h_valid_b = 1'b0;
  endtask

  task automatic addr_op(input bit wr, input logic [1:0] off, input logic [2:0] len,
                         input logic [31:0] wd, input string req);
    logic [31:0] rd, e;
    e = wr ? 32'd0 : m_cfg;
    acc(1'b0, 1'b0, wr, off, len, wd, 1, 1'b0, req, rd);
    if (wr && off == 2'd0 && len == 3'd4) m_cfg = wd;
    chk(req, "address port data", rd, e);
  endtask

  task automatic data_op(input bit wr, input logic [1:0] off, input int len,
                         input logic [31:0] wd, input string req);
    logic [31:0] rd, e, t, ewd, mask;
    logic [3:0]  ebe;
    int o, n;
    e = wr ? 32'd0 : exp_read(m_cfg, off, len);
    t = m_cfg | {30'd0, off};
    o = int'(t[7:0]);
    n = room_n(o, len);
    ebe = '0;
    for (int i = 0; i < n; i++) if ((o % 4) + i < 4) ebe[(o % 4) + i] = 1'b1;
    ewd = wd << (8 * (o % 4));
    mask = '0;
    for (int ln = 0; ln < 4; ln++) if (ebe[ln]) mask[8*ln +: 8] = 8'hFF;
    acc(1'b0, 1'b1, wr, off, 3'(len), wd, m_cfg[31] ? LAT + 1 : 1, m_cfg[31], req, rd);
    chk(req, "host data", rd, e);
    if (m_cfg[31]) begin
      chk(req, "request seen", {31'd0, seen}, 32'd1);
      chk("R5", "bus", {24'd0, s_bus}, {24'd0, t[23:16]});
      chk("R5", "devfn", {24'd0, s_dev}, {24'd0, t[15:8]});
      chk("R5", "reg offset", {24'd0, s_reg}, {24'd0, t[7:0]});
      chk("R6", "clipped length", {29'd0, s_len}, 32'(n));
      chk("R7", "byte enables", {28'd0, s_be}, {28'd0, ebe});
      if (wr) chk("R7", "lane write data", s_wd & mask, ewd & mask);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] rd;
    for (int dv = 0; dv < 8; dv++)
      for (int a = 0; a < 256; a++) mem[dv][a] = 8'((dv * 37 + a * 5) ^ 8'h5A);

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R3", "h_ready after reset", {31'd0, h_ready}, 32'd0);
    chk("R3", "d_req after reset", {31'd0, d_req}, 32'd0);
    addr_op(1'b0, 2'd0, 3'd4, '0, "R3");

    // window closed
    data_op(1'b0, 2'd0, 4, '0, "R4");
    data_op(1'b1, 2'd1, 2, 32'h0000_BEEF, "R4");

    // malformed address writes are ignored
    addr_op(1'b1, 2'd1, 3'd4, 32'h8000_0110, "R1");
    addr_op(1'b1, 2'd0, 3'd2, 32'h8000_0110, "R1");
    addr_op(1'b0, 2'd0, 3'd4, '0, "R1");

    // enable clear but other bits set
    addr_op(1'b1, 2'd0, 3'd4, 32'h0000_0110, "R1");
    data_op(1'b0, 2'd0, 4, '0, "R4");

    // open window: bus 0, devfn 1, offset 0x10
    addr_op(1'b1, 2'd0, 3'd4, 32'h8000_0110, "R1");
    addr_op(1'b0, 2'd2, 3'd1, '0, "R2");
    data_op(1'b1, 2'd0, 4, 32'hCAFE_F00D, "R7");
    data_op(1'b0, 2'd0, 4, '0, "R8");
    data_op(1'b0, 2'd1, 2, '0, "R8");
    data_op(1'b1, 2'd2, 2, 32'h0000_1234, "R7");
    data_op(1'b0, 2'd3, 1, '0, "R8");
    data_op(1'b1, 2'd2, 4, 32'h7766_5544, "R7");
    data_op(1'b0, 2'd0, 4, '0, "R8");

    // end of space clipping
    addr_op(1'b1, 2'd0, 3'd4, 32'h8000_03FC, "R1");
    data_op(1'b0, 2'd3, 4, '0, "R6");
    data_op(1'b1, 2'd3, 4, 32'hA1B2_C3D4, "R6");
    data_op(1'b0, 2'd0, 4, '0, "R6");
    addr_op(1'b1, 2'd0, 3'd4, 32'h8000_02FE, "R1");
    data_op(1'b0, 2'd0, 4, '0, "R6");
    data_op(1'b0, 2'd1, 3, '0, "R6");

    // absent targets
    addr_op(1'b1, 2'd0, 3'd4, 32'h8001_0110, "R1");
    data_op(1'b1, 2'd0, 4, 32'hDEAD_BEEF, "R9");
    data_op(1'b0, 2'd0, 4, '0, "R9");
    addr_op(1'b1, 2'd0, 3'd4, 32'h8000_2010, "R1");
    data_op(1'b0, 2'd0, 4, '0, "R9");
    addr_op(1'b1, 2'd0, 3'd4, 32'h8000_0110, "R1");
    data_op(1'b0, 2'd0, 4, '0, "R9");

    // reserved bits 30:24 do not reach the decode
    addr_op(1'b1, 2'd0, 3'd4, 32'hFF00_0214, "R5");
    data_op(1'b0, 2'd1, 2, '0, "R5");

    // big-endian instance
    acc(1'b1, 1'b0, 1'b1, 2'd0, 3'd4, 32'h1C00_0080, 1, 1'b0, "R11", rd);
    acc(1'b1, 1'b0, 1'b0, 2'd3, 3'd2, '0, 1, 1'b0, "R11", rd);
    chk("R11", "address readback", rd, 32'h1C00_0080);
    acc(1'b1, 1'b1, 1'b0, 2'd0, 3'd4, '0, 2, 1'b1, "R11", rd);
    chk("R11", "reversed 4-byte read", rd, 32'h1122_3344);
    chk("R11", "target offset", {24'd0, cap_b_reg}, 32'h0000_001C);
    acc(1'b1, 1'b1, 1'b0, 2'd2, 3'd2, '0, 2, 1'b1, "R11", rd);
    chk("R11", "reversed 2-byte read", rd, 32'h0000_3344);
    acc(1'b1, 1'b1, 1'b1, 2'd0, 3'd4, 32'hAABB_CCDD, 2, 1'b1, "R11", rd);
    chk("R11", "reversed write data", cap_b_wd, 32'hDDCC_BBAA);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule